// File: doc/BRIEF.md
# Interrupt Source and Mask Unit

This block gathers single-cycle event pulses from an Ethernet MAC core into a sticky source register. It drives one level-sensitive interrupt line towards the processor. Three events are tracked: a frame has gone out, a frame has come in, and an incoming frame was thrown away because no receive buffer was free. Each event sets its own bit. The bit stays set until software clears it by writing a one to that bit position.

A second register holds a per-event enable mask with the same bit layout. The interrupt output is registered. It is high while at least one source bit is set together with its mask bit. Software reaches both registers through a minimal register port: select, write strobe, address and write data. Read data is returned in the same cycle, and a read has no side effects.

Top module: `irq_src_mask`

## Requirements
- R1: After reset the source register and the mask register both read as zero and `irq` is low.
- R2: A pulse on `ev_tx` sets source bit 0, a pulse on `ev_rx` sets source bit 2, and a pulse on `ev_drop` sets source bit 4. Each bit is visible in a read of the source register (offset 0x04) from the cycle after the pulse.
- R3: A write to offset 0x04 clears every source bit whose position is one in the written data. Source bits whose position is zero in the written data keep their value.
- R4: If an event pulse and a write-one-to-clear of the same source bit happen in the same cycle, that bit remains set.
- R5: A write to offset 0x08 loads the mask register, which uses the same bit layout as the source register (bit 2 enables receive interrupts). The loaded value reads back from offset 0x08 in the next cycle. A source write leaves the mask unchanged, and a mask write leaves the source unchanged.
- R6: `irq` is high in the cycle after any source bit and its mask bit are both one, and it is low in the cycle after no such pair exists.
- R7: Only bits 0, 2 and 4 exist. All other bits read as zero, and writing them has no effect. Writes to any address other than 0x04 and 0x08 change nothing, and reads of those addresses return zero. `bus_rdata` is zero unless `bus_sel` is high and `bus_wr` is low.
- R8: Without an event or a clear, a source bit holds its value. Reading a register does not change any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx | input | 1 | Pulse: frame transmitted |
| ev_rx | input | 1 | Pulse: frame received |
| ev_drop | input | 1 | Pulse: received frame dropped, no free buffer |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Read data depends only on the current register contents, so the bench checks it in the access cycle, before the rising edge. Events and writes change the registers at the next rising edge, so their effect shows up in reads made one cycle later. The interrupt line is one register further along. It follows a source or mask change one edge after that change, which is two edges after the triggering pulse. The bench drives each step's inputs after a falling edge and checks `bus_rdata` shortly afterwards. It then updates its reference model at the rising edge and compares `irq` at the next falling edge, so every cycle's output is compared in the cycle it is due.

// File: rtl/irq_src_mask.sv
module irq_src_mask #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SRC_OFF  = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h08,
  parameter int TX_BIT   = 0,
  parameter int RX_BIT   = 2,
  parameter int DROP_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx,
  input  logic              ev_rx,
  input  logic              ev_drop,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam logic [DATA_W-1:0] VALID =
    (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT) | (DATA_W'(1) << DROP_BIT);

  logic [DATA_W-1:0] src_q, mask_q, ev_vec, clr_vec;
  logic              src_wr, mask_wr, irq_q;

  assign src_wr  = bus_sel && bus_wr && (bus_addr == SRC_OFF);
  assign mask_wr = bus_sel && bus_wr && (bus_addr == MASK_OFF);
  assign clr_vec = src_wr ? (bus_wdata & VALID) : '0;

  always_comb begin
    ev_vec           = '0;
    ev_vec[TX_BIT]   = ev_tx;
    ev_vec[RX_BIT]   = ev_rx;
    ev_vec[DROP_BIT] = ev_drop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      src_q <= ((src_q & ~clr_vec) | ev_vec) & VALID;
      if (mask_wr) mask_q <= bus_wdata & VALID;
      irq_q <= |(src_q & mask_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == SRC_OFF)       bus_rdata = src_q;
      else if (bus_addr == MASK_OFF) bus_rdata = mask_q;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_src_mask_chk.sv
module irq_src_mask_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SRC_OFF  = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h08,
  parameter int TX_BIT   = 0,
  parameter int RX_BIT   = 2,
  parameter int DROP_BIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_tx,
  input logic              ev_rx,
  input logic              ev_drop,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] src_q,
  input logic [DATA_W-1:0] mask_q
);

  localparam logic [DATA_W-1:0] VALID =
    (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT) | (DATA_W'(1) << DROP_BIT);

  logic wr_src, wr_mask;
  assign wr_src  = bus_sel && bus_wr && (bus_addr == SRC_OFF);
  assign wr_mask = bus_sel && bus_wr && (bus_addr == MASK_OFF);

  p_tx_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |=> src_q[TX_BIT]);

  p_drop_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> src_q[DROP_BIT]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src && bus_wdata[TX_BIT] && !ev_tx) |=> !src_q[TX_BIT]);

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src && bus_wdata[RX_BIT] && ev_rx) |=> src_q[RX_BIT]);

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_q & mask_q)) |=> irq);

  p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(src_q & mask_q)) |=> !irq);

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~VALID) == '0);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rx && !(wr_src && bus_wdata[RX_BIT])) |=> $stable(src_q[RX_BIT]));

endmodule

bind irq_src_mask irq_src_mask_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_OFF(SRC_OFF), .MASK_OFF(MASK_OFF),
  .TX_BIT(TX_BIT), .RX_BIT(RX_BIT), .DROP_BIT(DROP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_drop(ev_drop),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .src_q(src_q), .mask_q(mask_q)
);

// File: tb/tb_irq_src_mask.sv
`timescale 1ns/1ps
module tb_irq_src_mask;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_tx = 0, ev_rx = 0, ev_drop = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_src = 0, m_mask = 0;
  logic        m_irq = 0;

  always #10 clk = ~clk;

  irq_src_mask dut (
    .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_drop(ev_drop),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic s, input logic w, input logic [7:0] a);
    if (!s || w) return 32'h0;
    if (a == 8'h04) return m_src;
    if (a == 8'h08) return m_mask;
    return 32'h0;
  endfunction

  // One cycle: drive, check read data, clock, update model, check irq.
  task automatic step(input string req, input logic t, input logic r, input logic d,
                      input logic s, input logic w, input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] ev, clr;
    ev_tx = t; ev_rx = r; ev_drop = d;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
    #1;
    check(req, bus_rdata, exp_read(s, w, a));
    @(posedge clk);
    ev  = {27'b0, d, 1'b0, r, 1'b0, t};
    clr = (s && w && a == 8'h04) ? (wd & 32'h15) : 32'h0;
    m_irq = (m_src & m_mask) != 0;
    m_src = ((m_src & ~clr) | ev);
    if (s && w && a == 8'h08) m_mask = wd & 32'h15;
    @(negedge clk);
    check("R6", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    step(req, 0, 0, 0, 1, 0, a, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    rd("R1", 8'h04);
    rd("R1", 8'h08);
    // R2: each event to its bit
    step("R2", 1, 0, 0, 0, 0, 8'h00, 0);
    rd("R2", 8'h04);
    step("R2", 0, 1, 0, 0, 0, 8'h00, 0);
    step("R2", 0, 0, 1, 0, 0, 8'h00, 0);
    rd("R2", 8'h04);
    // R8: sticky, reads without side effect
    rd("R8", 8'h04);
    rd("R8", 8'h04);
    // R5: mask with only receive enabled, then all ones
    step("R5", 0, 0, 0, 1, 1, 8'h08, 32'h4);
    rd("R5", 8'h08);
    rd("R5", 8'h04);
    step("R7", 0, 0, 0, 1, 1, 8'h08, 32'hFFFF_FFFF);
    rd("R7", 8'h08);
    // R3: clear bit 0 only
    step("R3", 0, 0, 0, 1, 1, 8'h04, 32'h1);
    rd("R3", 8'h04);
    rd("R5", 8'h08);
    // R4: clear bit 2 with rx event in same cycle
    step("R4", 0, 1, 0, 1, 1, 8'h04, 32'h4);
    rd("R4", 8'h04);
    // R7: writes elsewhere ignored, reads elsewhere zero
    step("R7", 0, 0, 0, 1, 1, 8'h0C, 32'hFFFF_FFFF);
    step("R7", 0, 0, 0, 1, 1, 8'h00, 32'hFFFF_FFFF);
    rd("R7", 8'h0C);
    rd("R7", 8'h04);
    rd("R7", 8'h08);
    step("R7", 0, 0, 0, 0, 0, 8'h04, 0);
    // R6: clear everything, irq falls
    step("R3", 0, 0, 0, 1, 1, 8'h04, 32'hFFFF_FFFF);
    rd("R6", 8'h04);
    rd("R6", 8'h04);
    // R6: masked event does not raise irq
    step("R5", 0, 0, 0, 1, 1, 8'h08, 32'h4);
    step("R6", 1, 0, 1, 0, 0, 8'h00, 0);
    rd("R6", 8'h04);
    step("R6", 0, 1, 0, 0, 0, 8'h00, 0);
    rd("R6", 8'h04);
    // mixed traffic
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[9:8])
        2'd0: a = 8'h04;
        2'd1: a = 8'h08;
        2'd2: a = 8'h0C;
        default: a = 8'h04;
      endcase
      step("R3 R4 R8", lfsr[0], lfsr[3], lfsr[5], lfsr[12], lfsr[14] & lfsr[17],
           a, {lfsr[15:0], lfsr[31:16]});
    end
    // reset again mid-state
    rst_n = 1'b0;
    @(posedge clk);
    m_src = 0; m_mask = 0; m_irq = 0;
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 8'h04);
    rd("R1", 8'h08);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule